// File: doc/BRIEF.md
# DS3 CP-Bit Parity Error Monitor

This block watches a received DS3 bit stream that some upstream framer has already aligned. Each bit comes with a clock enable, and the first bit of every frame is marked by a start pulse. The block walks the frame structure of subframes, blocks and bit slots. It folds every payload bit into an even-parity sum and keeps that sum when the frame closes. The far end sends the parity of a frame inside the three CP overhead bits of the frame that follows it. The monitor therefore takes a majority vote of the three CP bits in each new frame and compares the result with the parity it kept from the frame before.

A mismatch counts as one errored frame. It sets a sticky status bit that is cleared when read, pulls an active-low interrupt down while that bit is enabled, and adds one to a saturating error counter. A periodic one-second pulse moves the running count into an accumulator and starts the count again. Software reads the status byte, both halves of the counter and both halves of the accumulator through a small byte-wide read port. Reading the high counter byte captures the low byte, so the two reads form one consistent value. The seven lower status bits come from other alarm logic through set inputs.

Top module: `ds3cp_monitor`

## Requirements
- R1: Frame parity is the XOR of the payload bits only. A bit is overhead when its slot index inside its block is 0. Overhead values never change the parity.
- R2: The received CP value is the majority of the overhead bits of blocks 2, 4 and 6 (0-based) in subframe CP_SUBFRAME. It is compared at the end of each frame with the parity kept from the previous frame, and a mismatch is a frame error.
- R3: No frame error is raised for the first complete frame after reset, or for the first complete frame after `in_frame` has been low.
- R4: A frame error sets status bit 7. `int_n` is low exactly while some status bit is 1 with the same bit of `int_enable` set.
- R5: The error counter goes up by exactly one per errored frame, whether two or three CP bits are wrong. A single wrong CP bit is outvoted and counts nothing.
- R6: The error counter stops at its all-ones value (2^CNT_W-1) and does not wrap.
- R7: A `sec_pulse` copies the running count into the accumulator and restarts the count from 0. A frame error in the same cycle leaves the new count at 1.
- R8: Read map, returned combinationally: address 0 is status, 1 is the counter high byte, 2 is the counter low byte as captured by the last read of address 1, 3 is the accumulator high byte, 4 is the accumulator low byte, and 5 to 7 return 0.
- R9: A read of address 0 returns the status and then clears it. A status bit set in the same cycle as the read survives the clear, and `int_n` goes high after the clearing read.
- R10: A pulse on `ext_set[k]` (k = 0..6) sets status bit k. Bit 0 is the P-bit error source.
- R11: After reset the status, counter and accumulator are 0 and `int_n` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_frame | input | 1 | Framer reports alignment; low discards frame and held parity |
| bit_en | input | 1 | A received bit is present this cycle |
| frame_start | input | 1 | With bit_en, marks the first bit of a frame |
| bit_in | input | 1 | Received bit |
| sec_pulse | input | 1 | One-second interval pulse |
| ext_set | input | 7 | Set strobes for status bits 6..0 |
| int_enable | input | 8 | Per-bit interrupt enables |
| rd_en | input | 1 | Read strobe |
| rd_addr | input | 3 | Read address |
| rd_data | output | 8 | Read data |
| int_n | output | 1 | Active-low interrupt |

## Verification
The hardest state to reach from the ports is a full counter. Reaching it takes hundreds of frames, and every one of them must carry CP bits that disagree with the parity of the frame before. The bench works at a reduced configuration: a 48-bit frame and a 9-bit counter. It computes each frame's payload parity as it shifts the bits in and writes deliberately flipped CP bits into the next frame, so it can drive the counter past 511. The same generator sweeps every pattern of flipped CP bits to exercise the majority vote, and it lines up a one-second pulse with the error pulse of a closing frame.

// File: rtl/ds3cp_pkg.sv
`timescale 1ns/1ps
package ds3cp_pkg;
    localparam logic [2:0] ADDR_STATUS = 3'd0;
    localparam logic [2:0] ADDR_CNT_HI = 3'd1;
    localparam logic [2:0] ADDR_CNT_LO = 3'd2;
    localparam logic [2:0] ADDR_ACC_HI = 3'd3;
    localparam logic [2:0] ADDR_ACC_LO = 3'd4;

    // number of CP bits carried per frame
    localparam int CP_COUNT = 3;

    function automatic logic vote3(input logic [2:0] v);
        return (v[0] & v[1]) | (v[0] & v[2]) | (v[1] & v[2]);
    endfunction
endpackage

// File: rtl/ds3cp_frame_walk.sv
`timescale 1ns/1ps
module ds3cp_frame_walk #(
    parameter int SUBFRAMES   = 7,
    parameter int BLOCKS      = 8,
    parameter int BLOCK_BITS  = 85,
    parameter int CP_SUBFRAME = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic in_frame,
    input  logic bit_en,
    input  logic frame_start,
    input  logic bit_in,
    output logic cp_err
);
    import ds3cp_pkg::*;

    localparam int SF_W  = (SUBFRAMES  > 1) ? $clog2(SUBFRAMES)  : 1;
    localparam int BLK_W = (BLOCKS     > 1) ? $clog2(BLOCKS)     : 1;
    localparam int BIT_W = (BLOCK_BITS > 1) ? $clog2(BLOCK_BITS) : 1;

    typedef struct packed {
        logic                aligned;
        logic [SF_W-1:0]     sf;
        logic [BLK_W-1:0]    blk;
        logic [BIT_W-1:0]    slot;
        logic                run_par;
        logic [CP_COUNT-1:0] cp;
        logic                held_par;
        logic                held_ok;
        logic                err;
    } walk_t;

    walk_t st_d, st_q;

    logic [SF_W-1:0]     cur_sf;
    logic [BLK_W-1:0]    cur_blk;
    logic [BIT_W-1:0]    cur_slot;
    logic                par_base;
    logic                par_new;
    logic                is_oh;
    logic                is_last;
    logic [CP_COUNT-1:0] cp_new;

    always_comb begin
        st_d     = st_q;
        st_d.err = 1'b0;
        cur_sf   = frame_start ? '0 : st_q.sf;
        cur_blk  = frame_start ? '0 : st_q.blk;
        cur_slot = frame_start ? '0 : st_q.slot;
        par_base = frame_start ? 1'b0 : st_q.run_par;
        is_oh    = (cur_slot == '0);
        par_new  = par_base ^ (bit_in & ~is_oh);
        is_last  = (cur_sf == SF_W'(SUBFRAMES - 1)) &&
                   (cur_blk == BLK_W'(BLOCKS - 1)) &&
                   (cur_slot == BIT_W'(BLOCK_BITS - 1));
        cp_new   = st_q.cp;
        for (int k = 0; k < CP_COUNT; k++) begin
            if (is_oh && cur_sf == SF_W'(CP_SUBFRAME) && cur_blk == BLK_W'(2 * k + 2))
                cp_new[k] = bit_in;
        end

        if (!in_frame) begin
            st_d.aligned = 1'b0;
            st_d.held_ok = 1'b0;
            st_d.sf      = '0;
            st_d.blk     = '0;
            st_d.slot    = '0;
            st_d.run_par = 1'b0;
        end else if (bit_en && (frame_start || st_q.aligned)) begin
            st_d.aligned = 1'b1;
            st_d.cp      = cp_new;
            if (is_last) begin
                st_d.err      = st_q.held_ok && (vote3(cp_new) != st_q.held_par);
                st_d.held_par = par_new;
                st_d.held_ok  = 1'b1;
                st_d.run_par  = 1'b0;
                st_d.sf       = '0;
                st_d.blk      = '0;
                st_d.slot     = '0;
            end else begin
                st_d.run_par = par_new;
                if (cur_slot == BIT_W'(BLOCK_BITS - 1)) begin
                    st_d.slot = '0;
                    if (cur_blk == BLK_W'(BLOCKS - 1)) begin
                        st_d.blk = '0;
                        st_d.sf  = cur_sf + 1'b1;
                    end else begin
                        st_d.blk = cur_blk + 1'b1;
                        st_d.sf  = cur_sf;
                    end
                end else begin
                    st_d.slot = cur_slot + 1'b1;
                    st_d.blk  = cur_blk;
                    st_d.sf   = cur_sf;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cp_err = st_q.err;
endmodule

// File: rtl/ds3cp_err_count.sv
`timescale 1ns/1ps
module ds3cp_err_count #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cp_err,
    input  logic             sec_pulse,
    input  logic             lo_capture,
    output logic [CNT_W-1:0] count,
    output logic [CNT_W-1:0] accum,
    output logic [7:0]       count_lo_shadow
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic [CNT_W-1:0] acc;
        logic [7:0]       shadow;
    } cnt_t;

    cnt_t st_d, st_q;
    logic [CNT_W-1:0] base;

    always_comb begin
        st_d = st_q;
        base = sec_pulse ? '0 : st_q.cnt;
        if (cp_err)
            st_d.cnt = (base == CNT_MAX) ? CNT_MAX : base + 1'b1;
        else
            st_d.cnt = base;
        if (sec_pulse)
            st_d.acc = st_q.cnt;
        if (lo_capture)
            st_d.shadow = st_q.cnt[7:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign count           = st_q.cnt;
    assign accum           = st_q.acc;
    assign count_lo_shadow = st_q.shadow;
endmodule

// File: rtl/ds3cp_status.sv
`timescale 1ns/1ps
module ds3cp_status (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cp_err,
    input  logic [6:0] ext_set,
    input  logic       rd_clear,
    input  logic [7:0] int_enable,
    output logic [7:0] status,
    output logic       int_n
);
    typedef struct packed {
        logic [7:0] bits;
    } stat_t;

    stat_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.bits = (rd_clear ? 8'h00 : st_q.bits) | {cp_err, ext_set};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign status = st_q.bits;
    assign int_n  = ~|(st_q.bits & int_enable);
endmodule

// File: rtl/ds3cp_monitor.sv
`timescale 1ns/1ps
module ds3cp_monitor #(
    parameter int SUBFRAMES   = 7,
    parameter int BLOCKS      = 8,
    parameter int BLOCK_BITS  = 85,
    parameter int CP_SUBFRAME = 2,
    parameter int CNT_W       = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       in_frame,
    input  logic       bit_en,
    input  logic       frame_start,
    input  logic       bit_in,
    input  logic       sec_pulse,
    input  logic [6:0] ext_set,
    input  logic [7:0] int_enable,
    input  logic       rd_en,
    input  logic [2:0] rd_addr,
    output logic [7:0] rd_data,
    output logic       int_n
);
    import ds3cp_pkg::*;

    logic             cp_err;
    logic [CNT_W-1:0] err_cnt;
    logic [CNT_W-1:0] err_acc;
    logic [7:0]       cnt_shadow;
    logic [7:0]       status;
    logic [15:0]      cnt16;
    logic [15:0]      acc16;
    logic             rd_status;
    logic             rd_cnt_hi;

    assign rd_status = rd_en && (rd_addr == ADDR_STATUS);
    assign rd_cnt_hi = rd_en && (rd_addr == ADDR_CNT_HI);
    assign cnt16     = 16'(err_cnt);
    assign acc16     = 16'(err_acc);

    ds3cp_frame_walk #(
        .SUBFRAMES  (SUBFRAMES),
        .BLOCKS     (BLOCKS),
        .BLOCK_BITS (BLOCK_BITS),
        .CP_SUBFRAME(CP_SUBFRAME)
    ) u_walk (
        .clk        (clk),
        .rst_n      (rst_n),
        .in_frame   (in_frame),
        .bit_en     (bit_en),
        .frame_start(frame_start),
        .bit_in     (bit_in),
        .cp_err     (cp_err)
    );

    ds3cp_err_count #(.CNT_W(CNT_W)) u_cnt (
        .clk            (clk),
        .rst_n          (rst_n),
        .cp_err         (cp_err),
        .sec_pulse      (sec_pulse),
        .lo_capture     (rd_cnt_hi),
        .count          (err_cnt),
        .accum          (err_acc),
        .count_lo_shadow(cnt_shadow)
    );

    ds3cp_status u_stat (
        .clk       (clk),
        .rst_n     (rst_n),
        .cp_err    (cp_err),
        .ext_set   (ext_set),
        .rd_clear  (rd_status),
        .int_enable(int_enable),
        .status    (status),
        .int_n     (int_n)
    );

    always_comb begin
        case (rd_addr)
            ADDR_STATUS: rd_data = status;
            ADDR_CNT_HI: rd_data = cnt16[15:8];
            ADDR_CNT_LO: rd_data = cnt_shadow;
            ADDR_ACC_HI: rd_data = acc16[15:8];
            ADDR_ACC_LO: rd_data = acc16[7:0];
            default:     rd_data = 8'h00;
        endcase
    end
endmodule

// File: rtl/ds3cp_monitor_chk.sv
`timescale 1ns/1ps
module ds3cp_monitor_chk #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             in_frame,
    input logic             sec_pulse,
    input logic             rd_en,
    input logic [2:0]       rd_addr,
    input logic [6:0]       ext_set,
    input logic             cp_err,
    input logic [CNT_W-1:0] cnt,
    input logic [CNT_W-1:0] acc,
    input logic [7:0]       status,
    input logic             int_n
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    AST_NO_CHECK_UNALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
        !in_frame |=> !cp_err); // R3

    AST_ERR_SETS_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
        cp_err |=> status[7]); // R4

    AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (cp_err && !sec_pulse && cnt != CNT_MAX) |=> cnt == $past(cnt) + 1'b1); // R5

    AST_CNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!cp_err && !sec_pulse) |=> $stable(cnt)); // R5

    AST_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (cp_err && !sec_pulse && cnt == CNT_MAX) |=> cnt == CNT_MAX); // R6

    AST_SEC_SNAP: assert property (@(posedge clk) disable iff (!rst_n)
        sec_pulse |=> (acc == $past(cnt)) && (cnt == CNT_W'($past(cp_err)))); // R7

    AST_CLEAR_ON_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && rd_addr == 3'd0 && !cp_err && ext_set == 7'd0) |=> (status == 8'h00) && int_n); // R9
endmodule

bind ds3cp_monitor ds3cp_monitor_chk #(.CNT_W(CNT_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_frame (in_frame),
    .sec_pulse(sec_pulse),
    .rd_en    (rd_en),
    .rd_addr  (rd_addr),
    .ext_set  (ext_set),
    .cp_err   (cp_err),
    .cnt      (err_cnt),
    .acc      (err_acc),
    .status   (status),
    .int_n    (int_n)
);

// File: tb/sim_ds3cp_monitor.sv
`timescale 1ns/1ps
module sim_ds3cp_monitor;
    localparam int SUBFRAMES   = 2;
    localparam int BLOCKS      = 8;
    localparam int BLOCK_BITS  = 3;
    localparam int CP_SUBFRAME = 1;
    localparam int CNT_W       = 9;
    localparam int FRAME_BITS  = SUBFRAMES * BLOCKS * BLOCK_BITS;
    localparam int CNT_MAX     = (1 << CNT_W) - 1;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       in_frame = 1'b0;
    logic       bit_en = 1'b0;
    logic       frame_start = 1'b0;
    logic       bit_in = 1'b0;
    logic       sec_pulse = 1'b0;
    logic [6:0] ext_set = 7'd0;
    logic [7:0] int_enable = 8'hFF;
    logic       rd_en = 1'b0;
    logic [2:0] rd_addr = 3'd0;
    logic [7:0] rd_data;
    logic       int_n;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic [15:0] lfsr = 16'hACE1;
    logic        prev_par = 1'b0;
    bit          prev_ok = 1'b0;
    int          exp_cnt = 0;
    int          exp_acc = 0;
    logic [7:0]  exp_stat = 8'h00;

    always #2 clk = ~clk;

    ds3cp_monitor #(
        .SUBFRAMES(SUBFRAMES), .BLOCKS(BLOCKS), .BLOCK_BITS(BLOCK_BITS),
        .CP_SUBFRAME(CP_SUBFRAME), .CNT_W(CNT_W)
    ) u0 (
        .clk(clk), .rst_n(rst_n), .in_frame(in_frame), .bit_en(bit_en),
        .frame_start(frame_start), .bit_in(bit_in), .sec_pulse(sec_pulse),
        .ext_set(ext_set), .int_enable(int_enable), .rd_en(rd_en),
        .rd_addr(rd_addr), .rd_data(rd_data), .int_n(int_n)
    );

    task automatic check(input string req, input int got, input int exp);
        checks++;
        if (got != exp) begin
            errors++;
            $display("FAIL %s got=%0h exp=%0h", req, got, exp);
        end
    endtask

    task automatic rd(input logic [2:0] a, output logic [7:0] d);
        @(negedge clk);
        rd_en = 1'b1;
        rd_addr = a;
        #1 d = rd_data;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic check_cnt(input string req);
        logic [7:0] hi, lo;
        rd(3'd1, hi);
        rd(3'd2, lo);
        check(req, {hi, lo}, exp_cnt);
    endtask

    task automatic check_acc(input string req);
        logic [7:0] hi, lo;
        rd(3'd3, hi);
        rd(3'd4, lo);
        check(req, {hi, lo}, exp_acc);
    endtask

    task automatic check_stat(input string req);
        logic [7:0] s;
        rd(3'd0, s);
        check(req, s, exp_stat);
        exp_stat = 8'h00;
    endtask

    task automatic check_int(input string req);
        @(negedge clk);
        #1 check(req, int_n, (exp_stat & int_enable) == 8'h00);
    endtask

    function automatic logic maj(input logic [2:0] v);
        return (v[0] & v[1]) | (v[0] & v[2]) | (v[1] & v[2]);
    endfunction

    // flip: CP bits to invert; oh_ones: other overhead all 1; sec: one-second pulse aligned to the error pulse
    task automatic send_frame(input logic [2:0] flip, input bit oh_ones, input bit sec);
        logic       par = 1'b0;
        logic [2:0] cpv = 3'b000;
        int         ci = 0;
        bit         err;
        for (int i = 0; i < FRAME_BITS; i++) begin
            int   sf  = i / (BLOCKS * BLOCK_BITS);
            int   blk = (i / BLOCK_BITS) % BLOCKS;
            int   b   = i % BLOCK_BITS;
            logic v;
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            if (b == 0) begin
                if (sf == CP_SUBFRAME && (blk == 2 || blk == 4 || blk == 6)) begin
                    v = prev_par ^ flip[ci];
                    cpv[ci] = v;
                    ci++;
                end else begin
                    v = oh_ones ? 1'b1 : lfsr[0];
                end
            end else begin
                v = lfsr[0];
                par = par ^ v;
            end
            @(negedge clk);
            bit_en = 1'b1;
            bit_in = v;
            frame_start = (i == 0);
        end
        @(negedge clk);
        bit_en = 1'b0;
        frame_start = 1'b0;
        bit_in = 1'b0;
        sec_pulse = sec;
        @(negedge clk);
        sec_pulse = 1'b0;
        @(negedge clk);
        err = prev_ok && (maj(cpv) != prev_par);
        if (sec) begin
            exp_acc = exp_cnt;
            exp_cnt = 0;
        end
        if (err) begin
            exp_cnt = (exp_cnt == CNT_MAX) ? CNT_MAX : exp_cnt + 1;
            exp_stat[7] = 1'b1;
        end
        prev_par = par;
        prev_ok = 1'b1;
    endtask

    task automatic pulse_sec();
        @(negedge clk);
        sec_pulse = 1'b1;
        @(negedge clk);
        sec_pulse = 1'b0;
        exp_acc = exp_cnt;
        exp_cnt = 0;
    endtask

    task automatic report();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
    endtask

    initial begin
        #(4 * 150000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            report();
            $finish;
        end
    end

    initial begin
        logic [7:0] d;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        in_frame = 1'b1;

        // R11 reset state
        check_int("R11 int_n after reset");
        check_stat("R11 status after reset");
        check_cnt("R11 counter after reset");
        check_acc("R11 accumulator after reset");

        // R3 first frame not compared, even with all CP bits wrong
        send_frame(3'b111, 1'b0, 1'b0);
        check_cnt("R3 first frame after reset");

        // R2 R5 sweep of every CP flip pattern
        for (int f = 0; f < 8; f++) begin
            for (int r = 0; r < 2; r++) begin
                send_frame(3'(f), 1'b0, 1'b0);
                check_cnt($sformatf("R5 R2 flip=%0d", f));
            end
        end

        // R4 R9 interrupt and clear on read
        check_int("R4 int_n low after errors");
        check_stat("R9 status after CP errors");
        check_int("R9 int_n released");
        check_stat("R9 status cleared");

        // R4 masked bit keeps int_n high
        int_enable = 8'h7F;
        send_frame(3'b011, 1'b0, 1'b0);
        check_int("R4 masked int_n");
        check_stat("R4 masked status");
        int_enable = 8'hFF;

        // R1 overhead values ignored by parity
        send_frame(3'b000, 1'b1, 1'b0);
        send_frame(3'b000, 1'b0, 1'b0);
        check_cnt("R1 overhead all ones");
        check_stat("R1 no status");

        // R10 external sources
        for (int k = 0; k < 7; k++) begin
            @(negedge clk);
            ext_set = 7'(1 << k);
            @(negedge clk);
            ext_set = 7'd0;
            exp_stat[k] = 1'b1;
            check_int($sformatf("R10 int_n bit %0d", k));
            check_stat($sformatf("R10 status bit %0d", k));
        end

        // R9 set in the same cycle as the clearing read
        @(negedge clk);
        rd_en = 1'b1;
        rd_addr = 3'd0;
        ext_set = 7'd1;
        #1 d = rd_data;
        @(negedge clk);
        rd_en = 1'b0;
        ext_set = 7'd0;
        check("R9 read during set", d, 8'h00);
        exp_stat = 8'h01;
        check_stat("R9 set wins over clear");

        // R7 one-second snapshot
        pulse_sec();
        check_acc("R7 accumulator snapshot");
        check_cnt("R7 count restarted");
        send_frame(3'b110, 1'b0, 1'b0);
        send_frame(3'b101, 1'b0, 1'b0);
        send_frame(3'b111, 1'b0, 1'b1);
        check_acc("R7 snapshot with coincident error");
        check_cnt("R7 coincident error in new interval");

        // R8 shadow coherence and unused addresses
        rd(3'd1, d);
        send_frame(3'b111, 1'b0, 1'b0);
        rd(3'd2, d);
        check("R8 low byte from shadow", d, (exp_cnt - 1) & 8'hFF);
        check_cnt("R8 coherent pair");
        for (int a = 5; a < 8; a++) begin
            rd(3'(a), d);
            check($sformatf("R8 address %0d", a), d, 0);
        end
        check_stat("R8 status after frames");

        // R3 in_frame drop discards held parity
        @(negedge clk);
        in_frame = 1'b0;
        repeat (4) @(negedge clk);
        in_frame = 1'b1;
        prev_ok = 1'b0;
        send_frame(3'b111, 1'b0, 1'b0);
        check_cnt("R3 first frame after in_frame low");
        send_frame(3'b000, 1'b0, 1'b0);
        check_cnt("R3 good frame after realign");
        send_frame(3'b011, 1'b0, 1'b0);
        check_cnt("R3 compare resumes");
        check_stat("R3 status");

        // R6 saturation
        pulse_sec();
        for (int n = 0; n < CNT_MAX + 6; n++) send_frame(3'b111, 1'b0, 1'b0);
        check_cnt("R6 counter saturated");
        pulse_sec();
        check_acc("R6 saturated value in accumulator");
        check_stat("R6 status");

        done = 1'b1;
        report();
        $finish;
    end
endmodule